// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block computes an add, subtract or bitwise logic result on two operands at one of three operand sizes (8, 16 or 32 bits). Alongside the result it derives six condition flags: carry (borrow on subtract), signed overflow, sign, zero, a carry across the nibble boundary, and even parity of the low byte. The result and the live flag vector are combinational. A six-bit flag register captures the live flags on a write strobe, so an execution stage can choose which operations leave their condition codes behind.

The operand size selects which operand bits take part. All flag definitions are taken at that size. Result bits above the selected size always read as zero.

Top module: `alu_flag_unit`

## Requirements
- R1: `op` selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 pass B. `size` selects the width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Operands are truncated to that width, and result bits above it are zero.
- R2: Carry is set when an unsigned sum exceeds the width. For subtract it is set when A < B + borrow as unsigned values.
- R3: Overflow is set when the signed (two's complement) result of an add or subtract falls outside the range of the selected width.
- R4: Sign equals the most significant result bit at the selected width.
- R5: Zero is set when the result at the selected width is all zeros.
- R6: Auxiliary carry is set on a carry out of bit 3 into bit 4 for add. For subtract it is set on a borrow from bit 4 into bit 3.
- R7: Parity is set when the low 8 bits of the result contain an even number of ones, whatever the size.
- R8: Logic operations and pass B force carry, overflow and auxiliary carry to 0.
- R9: `flags_q` loads `flags_now` at a rising clock edge when `flag_we` is high, and holds its value otherwise.
- R10: An active-low reset clears `flags_q` to zero.
- R11: Both flag vectors use this bit order: [0] carry, [1] parity, [2] auxiliary carry, [3] zero, [4] sign, [5] overflow.
- R12: `cin` is used only by op 1 and op 3. All other operations ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| op | input | 3 | Operation select |
| size | input | 2 | Operand width select |
| cin | input | 1 | Carry or borrow in |
| flag_we | input | 1 | Flag register write enable |
| result | output | 32 | Result, zero above the selected width |
| flags_now | output | 6 | Live flags for the current inputs |
| flags_q | output | 6 | Registered flags |

## Verification
At byte size, add and subtract are swept over every operand pair. This exposes a carry or borrow taken at the wrong bit position, an overflow rule that confuses the add and subtract sign cases, and a nibble carry taken at the wrong boundary. Word and doubleword sizes use pairs built from boundary values such as 0x7FFF, 0x8000 and 0xFFFFFFFF, so a design that took the sign or carry from the wrong width would misreport there. Every sweep also drives `cin` high for plain add, subtract and logic operations, which catches a carry leaking into operations that must ignore it. The register is checked for loading, holding with the strobe low, and clearing on reset.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic        cin,
  input  logic        flag_we,
  output logic [31:0] result,
  output logic [5:0]  flags_now,
  output logic [5:0]  flags_q
);
  localparam int F_C = 0, F_P = 1, F_A = 2, F_Z = 3, F_S = 4, F_O = 5;

  logic [31:0] mask, am, bm;
  logic [32:0] raw;
  logic        arith, is_sub, cuse, sa, sb, sr, cy;

  assign mask   = (size == 2'd0) ? 32'h0000_00FF :
                  (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign am     = a & mask;
  assign bm     = b & mask;
  assign arith  = ~op[2];
  assign is_sub = arith & op[1];
  assign cuse   = arith & op[0] & cin;

  always_comb begin
    case (op)
      3'd0, 3'd1: raw = {1'b0, am} + {1'b0, bm} + 33'(cuse);
      3'd2, 3'd3: raw = {1'b0, am} - {1'b0, bm} - 33'(cuse);
      3'd4:       raw = {1'b0, am & bm};
      3'd5:       raw = {1'b0, am | bm};
      3'd6:       raw = {1'b0, am ^ bm};
      default:    raw = {1'b0, bm};
    endcase
  end

  assign result = raw[31:0] & mask;

  always_comb begin
    case (size)
      2'd0:    begin sa = am[7];  sb = bm[7];  sr = result[7];  cy = raw[8];  end
      2'd1:    begin sa = am[15]; sb = bm[15]; sr = result[15]; cy = raw[16]; end
      default: begin sa = am[31]; sb = bm[31]; sr = result[31]; cy = raw[32]; end
    endcase
  end

  assign flags_now[F_C] = arith & cy;
  assign flags_now[F_P] = ~^result[7:0];
  assign flags_now[F_A] = arith & (a[4] ^ b[4] ^ raw[4]);
  assign flags_now[F_Z] = (result == 32'd0);
  assign flags_now[F_S] = sr;
  assign flags_now[F_O] = arith & (is_sub ? (sa != sb) : (sa == sb)) & (sr != sa);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flags_q <= 6'd0;
    else if (flag_we) flags_q <= flags_now;

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags_q == $past(flags_now));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));
  a_r8_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    op[2] |-> (flags_now[F_C] == 1'b0 && flags_now[F_O] == 1'b0 && flags_now[F_A] == 1'b0));
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now[F_Z] == (result == 32'd0));
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd0) |-> (result[31:8] == 24'd0));
endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic        cin = 1'b0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic [5:0]  flags_now, flags_q;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .size(size), .cin(cin),
    .flag_we(flag_we), .result(result), .flags_now(flags_now), .flags_q(flags_q));

  // Independent model; flag layout per R11: {O,S,Z,A,P,C}
  function automatic void model(input logic [2:0] o, input logic [1:0] sz,
      input logic [31:0] x, input logic [31:0] y, input logic c_in,
      output logic [31:0] r_exp, output logic [5:0] f_exp);
    longint m, half, ua, ub, sa, sb, s, ss, cc, r;
    logic c, v, ac;
    m = (sz == 0) ? 64'd256 : (sz == 1) ? 64'd65536 : 64'd4294967296;
    half = m / 2;
    ua = longint'(x) & (m - 1);
    ub = longint'(y) & (m - 1);
    sa = (ua >= half) ? ua - m : ua;
    sb = (ub >= half) ? ub - m : ub;
    cc = (o == 1 || o == 3) ? longint'(c_in) : 0; // R12
    c = 0; v = 0; ac = 0; r = 0;
    case (o)
      0, 1: begin
        s = ua + ub + cc; r = s & (m - 1); c = (s >= m);
        ss = sa + sb + cc; v = (ss >= half) || (ss < -half);
        ac = ((ua % 16) + (ub % 16) + cc) >= 16;
      end
      2, 3: begin
        s = ua - ub - cc; r = s & (m - 1); c = (s < 0);
        ss = sa - sb - cc; v = (ss >= half) || (ss < -half);
        ac = ((ua % 16) - (ub % 16) - cc) < 0;
      end
      4: r = ua & ub;
      5: r = ua | ub;
      6: r = ua ^ ub;
      default: r = ub;
    endcase
    r_exp = r[31:0];
    f_exp = {v, (r >= half), (r == 0), ac, ($countones(r[7:0]) % 2 == 0), c};
  endfunction

  task automatic apply(input logic [2:0] o, input logic [1:0] sz,
      input logic [31:0] x, input logic [31:0] y, input logic c_in);
    logic [31:0] re;
    logic [5:0] fe;
    op = o; size = sz; a = x; b = y; cin = c_in;
    #1;
    model(o, sz, x, y, c_in, re, fe);
    vectors++;
    if (result !== re || flags_now !== fe) begin
      miscompares++;
      if (result !== re) $display("FAIL R1 op=%0d sz=%0d a=%h b=%h cin=%0b result=%h expected=%h", o, sz, x, y, c_in, result, re);
      if (flags_now[0] !== fe[0]) $display("FAIL R2 carry op=%0d sz=%0d a=%h b=%h cin=%0b got=%0b expected=%0b", o, sz, x, y, c_in, flags_now[0], fe[0]);
      if (flags_now[5] !== fe[5]) $display("FAIL R3 overflow op=%0d sz=%0d a=%h b=%h got=%0b expected=%0b", o, sz, x, y, flags_now[5], fe[5]);
      if (flags_now[4] !== fe[4]) $display("FAIL R4 sign op=%0d sz=%0d a=%h b=%h got=%0b expected=%0b", o, sz, x, y, flags_now[4], fe[4]);
      if (flags_now[3] !== fe[3]) $display("FAIL R5 zero op=%0d sz=%0d a=%h b=%h got=%0b expected=%0b", o, sz, x, y, flags_now[3], fe[3]);
      if (flags_now[2] !== fe[2]) $display("FAIL R6 aux op=%0d sz=%0d a=%h b=%h got=%0b expected=%0b", o, sz, x, y, flags_now[2], fe[2]);
      if (flags_now[1] !== fe[1]) $display("FAIL R7 parity op=%0d sz=%0d a=%h b=%h got=%0b expected=%0b", o, sz, x, y, flags_now[1], fe[1]);
    end
    #1;
  endtask

  task automatic check_reg(input logic [5:0] exp, input string tag);
    vectors++;
    if (flags_q !== exp) begin
      miscompares++;
      $display("FAIL %s flags_q=%b expected=%b", tag, flags_q, exp);
    end
  endtask

  logic [31:0] corner [16] = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000, 32'hFFFF,
                               32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hF, 32'h10,
                               32'h1234_5678, 32'hDEAD_BEEF, 32'hF0F0_F0F0};

  initial begin
    logic [31:0] re;
    logic [5:0] fe, saved;
    #1;
    check_reg(6'd0, "R10 reset");
    #10;
    @(negedge clk); rst_n = 1'b1;
    check_reg(6'd0, "R10 after release");

    // Exhaustive byte add/sub; cin toggled and must be ignored (R12)
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        apply(3'd0, 2'd0, 32'(x) | 32'hAB00_0000, 32'(y), x[0] ^ y[0]);
        apply(3'd2, 2'd0, 32'(x), 32'(y) | 32'h0055_0000, x[1] ^ y[0]);
      end
    // Carry-in variants and logic ops at byte size (R8, R12)
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y += 7)
        for (int o = 1; o < 8; o++)
          if (o != 2) apply(3'(o), 2'd0, 32'(x), 32'(y), x[2] ^ y[1]);
    // Word and doubleword corners (R1..R7 at wider sizes)
    for (int sz = 1; sz < 4; sz++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          for (int o = 0; o < 8; o++)
            for (int c = 0; c < 2; c++)
              apply(3'(o), 2'(sz), corner[i], corner[j], c[0]);

    // R9 load then hold; R11 positions via model layout
    @(negedge clk);
    op = 3'd2; size = 2'd0; a = 32'h10; b = 32'h20; cin = 1'b0; flag_we = 1'b1;
    model(3'd2, 2'd0, 32'h10, 32'h20, 1'b0, re, fe);
    @(negedge clk);
    check_reg(fe, "R9 load");
    saved = fe;
    flag_we = 1'b0; op = 3'd4; a = 32'h0; b = 32'h0;
    @(negedge clk); @(negedge clk);
    check_reg(saved, "R9 hold");
    op = 3'd0; size = 2'd2; a = 32'h7FFF_FFFF; b = 32'h1; flag_we = 1'b1;
    model(3'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 1'b0, re, fe);
    @(negedge clk);
    check_reg(fe, "R11 overflow/sign layout");
    flag_we = 1'b0;
    rst_n = 1'b0; #1;
    check_reg(6'd0, "R10 mid-run reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_reg(6'd0, "R10 stays clear");
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    #20;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule